// File: doc/BRIEF.md
# Digital Optical-Black Clamp Controller

This block closes a black-level calibration loop in the digital domain for an image sensor front end. Conversion results arrive as a stream of 12-bit samples. While the optical-black clamp window is open, each accepted sample is compared against a programmed pedestal target. A 10-bit correction code then moves one step in the direction that pulls the sample toward the target. The correction code is meant to drive an external offset DAC. The block also drives the pedestal target level itself, so downstream logic can subtract it.

The clamp window strobe has a programmable polarity. The loop is frozen while blanking is in force and while the front end is in standby; in standby the strobe is masked off. The pedestal code is held in a small register that is written through a one-cycle write strobe. After reset the pedestal code holds its default value, and the correction code sits at mid-scale.

The sample input is a valid/ready stream. `smp_ready` is held high at all times, so the block never applies back-pressure. A sample counts only in a cycle where `smp_valid` and `smp_ready` are both high. A cycle without `smp_valid` never changes the loop.

Top module: `ob_clamp_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, before any other stimulus, `corr_code` is 512 and `target_lvl` is 130 (pedestal code 8). Reset is asynchronous and active low.
- R2: A pedestal write (`ped_wr`=1 with code k on `ped_code`) makes `target_lvl` equal 2 + 16·k from the cycle after the write edge, for k from 0 to 15 (range 2 to 242). A sample qualified in the same cycle as the write is compared against the old target.
- R3: A qualified sample greater than `target_lvl` lowers `corr_code` by 1. A qualified sample less than `target_lvl` raises it by 1. Either change is visible in the cycle after the sampling edge.
- R4: A qualified sample equal to `target_lvl` leaves `corr_code` unchanged.
- R5: `corr_code` saturates. It stays at 0 when more samples arrive above the target, and it stays at 1023 when more samples arrive below the target. It never wraps.
- R6: With `win_pol`=0 the window is open while `clamp_win`=0. With `win_pol`=1 the window is open while `clamp_win`=1. A sample taken while the window is closed leaves `corr_code` unchanged.
- R7: While `blank`=1, samples leave `corr_code` unchanged even when the window is open.
- R8: While `standby`=1, the window is treated as closed, and samples leave `corr_code` unchanged.
- R9: `smp_ready` is 1 at all times. In a cycle with `smp_valid`=0, `corr_code` is unchanged whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, always 1 |
| smp_data | input | 12 | Conversion result, straight binary |
| clamp_win | input | 1 | Raw optical-black window strobe |
| win_pol | input | 1 | Strobe polarity: 0 = open when low, 1 = open when high |
| blank | input | 1 | Blanking in force when 1 |
| standby | input | 1 | Standby when 1; masks the window strobe |
| ped_wr | input | 1 | Pedestal code write strobe |
| ped_code | input | 4 | Pedestal code to write |
| corr_code | output | 10 | Offset correction code for the DAC |
| target_lvl | output | 12 | Current pedestal target in LSBs |

## Verification
Every result of this block is due exactly one clock edge after its cause. A qualified sample changes `corr_code` after that edge, and a pedestal write changes `target_lvl` after the write edge. The one exception is reset, which acts at once. The bench drives inputs on the falling edge. A behavioural model updates on the same rising edge as the design, and the bench compares both outputs with the model on the next falling edge, so every check falls in the cycle where the result is due. Saturation at both rails is reached by long runs of one-sided samples, and a randomized mixed run then covers the gating inputs together.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;
  // Pedestal level in LSBs for a given code.
  function automatic int ped_level(input int base, input int step, input int code);
    return base + step * code;
  endfunction

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } step_dir_e;
endpackage

// File: rtl/ob_win_qual.sv
module ob_win_qual (
  input  logic clamp_win,
  input  logic win_pol,
  input  logic blank,
  input  logic standby,
  input  logic smp_valid,
  output logic upd_en
);
  logic win_open;

  // Polarity select, then standby mask, then blanking freeze.
  always_comb begin
    win_open = win_pol ? clamp_win : ~clamp_win;
    if (standby) win_open = 1'b0;
    upd_en = win_open & ~blank & smp_valid;
  end
endmodule

// File: rtl/ob_ped_reg.sv
module ob_ped_reg #(
  parameter int PED_W    = 4,
  parameter int DATA_W   = 12,
  parameter int PED_BASE = 2,
  parameter int PED_STEP = 16,
  parameter int PED_DEF  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [PED_W-1:0]  code_in,
  output logic [DATA_W-1:0] target
);
  localparam bit STEP_POW2 = (PED_STEP & (PED_STEP - 1)) == 0;
  localparam int STEP_SH   = $clog2(PED_STEP);

  logic [PED_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code_q <= PED_W'(PED_DEF);
    else if (wr) code_q <= code_in;
  end

  generate
    if (STEP_POW2) begin : g_shift
      assign target = DATA_W'(PED_BASE) + (DATA_W'(code_q) << STEP_SH);
    end else begin : g_mult
      assign target = DATA_W'(PED_BASE) + DATA_W'(code_q) * DATA_W'(PED_STEP);
    end
  endgenerate
endmodule

// File: rtl/ob_corr_acc.sv
module ob_corr_acc
  import ob_clamp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] target,
  output logic [CODE_W-1:0] corr
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

  step_dir_e   dir;
  logic [CODE_W-1:0] corr_q;

  // Sample above target -> lower the correction; below -> raise it.
  always_comb begin
    dir = DIR_HOLD;
    if (en) begin
      if (sample > target && corr_q != '0)            dir = DIR_DOWN;
      else if (sample < target && corr_q != CODE_MAX) dir = DIR_UP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= CODE_MID;
    else begin
      case (dir)
        DIR_UP:   corr_q <= corr_q + 1'b1;
        DIR_DOWN: corr_q <= corr_q - 1'b1;
        default:  corr_q <= corr_q;
      endcase
    end
  end

  assign corr = corr_q;
endmodule

// File: rtl/ob_clamp_ctrl.sv
module ob_clamp_ctrl #(
  parameter int DATA_W   = 12,
  parameter int CODE_W   = 10,
  parameter int PED_W    = 4,
  parameter int PED_BASE = 2,
  parameter int PED_STEP = 16,
  parameter int PED_DEF  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              clamp_win,
  input  logic              win_pol,
  input  logic              blank,
  input  logic              standby,
  input  logic              ped_wr,
  input  logic [PED_W-1:0]  ped_code,
  output logic [CODE_W-1:0] corr_code,
  output logic [DATA_W-1:0] target_lvl
);
  logic upd_en;

  assign smp_ready = 1'b1;

  ob_win_qual u_qual (
    .clamp_win (clamp_win),
    .win_pol   (win_pol),
    .blank     (blank),
    .standby   (standby),
    .smp_valid (smp_valid),
    .upd_en    (upd_en)
  );

  ob_ped_reg #(
    .PED_W(PED_W), .DATA_W(DATA_W), .PED_BASE(PED_BASE),
    .PED_STEP(PED_STEP), .PED_DEF(PED_DEF)
  ) u_ped (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ped_wr),
    .code_in (ped_code),
    .target  (target_lvl)
  );

  ob_corr_acc #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (upd_en),
    .sample (smp_data),
    .target (target_lvl),
    .corr   (corr_code)
  );
endmodule

// File: rtl/ob_clamp_chk.sv
module ob_clamp_chk #(
  parameter int DATA_W = 12,
  parameter int CODE_W = 10,
  parameter int PED_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [DATA_W-1:0] smp_data,
  input logic              clamp_win,
  input logic              win_pol,
  input logic              blank,
  input logic              standby,
  input logic              ped_wr,
  input logic [PED_W-1:0]  ped_code,
  input logic [CODE_W-1:0] corr_code,
  input logic [DATA_W-1:0] target_lvl
);
  logic opened;
  assign opened = smp_valid && !standby && !blank && (clamp_win == win_pol);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_vals_r1: assert (corr_code == CODE_W'(512) && target_lvl == DATA_W'(130));
    end
  end

  p_target_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    target_lvl[3:0] == 4'd2 && target_lvl <= DATA_W'(242));

  p_write_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ped_wr |=> target_lvl == DATA_W'(2) + DATA_W'($past(ped_code)) * DATA_W'(16));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opened && smp_data > target_lvl) |=>
      (corr_code == $past(corr_code) - 10'd1) || (corr_code == '0 && $past(corr_code) == '0));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opened && smp_data < target_lvl) |=>
      (corr_code == $past(corr_code) + 10'd1) || (&corr_code && &$past(corr_code)));

  p_equal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opened && smp_data == target_lvl) |=> $stable(corr_code));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(corr_code) == '0 && &corr_code) || (&$past(corr_code) && corr_code == '0)));

  p_closed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_win != win_pol) |=> $stable(corr_code));

  p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> $stable(corr_code));

  p_standby_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(corr_code));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(corr_code));

  p_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n) smp_ready);
endmodule

bind ob_clamp_ctrl ob_clamp_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .PED_W(PED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_data(smp_data), .clamp_win(clamp_win), .win_pol(win_pol), .blank(blank),
  .standby(standby), .ped_wr(ped_wr), .ped_code(ped_code),
  .corr_code(corr_code), .target_lvl(target_lvl)
);

// File: tb/tb_ob_clamp_ctrl.sv
`timescale 1ns/1ps
module tb_ob_clamp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_data = '0;
  logic        clamp_win = 1'b1;
  logic        win_pol = 1'b0;
  logic        blank = 1'b0;
  logic        standby = 1'b0;
  logic        ped_wr = 1'b0;
  logic [3:0]  ped_code = '0;
  logic [9:0]  corr_code;
  logic [11:0] target_lvl;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    armed = 1'b0;
  bit    finished = 1'b0;
  string req = "R1";

  int m_corr = 512;
  int m_code = 8;

  always #5 clk = ~clk;

  ob_clamp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .clamp_win(clamp_win), .win_pol(win_pol), .blank(blank),
    .standby(standby), .ped_wr(ped_wr), .ped_code(ped_code),
    .corr_code(corr_code), .target_lvl(target_lvl)
  );

  // Behavioural reference model.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_corr = 512;
      m_code = 8;
    end else begin
      int  tgt;
      bit  open;
      tgt  = 2 + 16 * m_code;
      open = (win_pol ? clamp_win : !clamp_win) && !standby && !blank && smp_valid;
      if (open) begin
        if (int'(smp_data) > tgt && m_corr > 0) m_corr = m_corr - 1;
        else if (int'(smp_data) < tgt && m_corr < 1023) m_corr = m_corr + 1;
      end
      if (ped_wr) m_code = int'(ped_code);
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      n_chk++;
      if (int'(corr_code) != m_corr) begin
        n_fail++;
        $display("FAIL %s corr_code actual %0d expected %0d", req, corr_code, m_corr);
      end
      n_chk++;
      if (int'(target_lvl) != 2 + 16 * m_code) begin
        n_fail++;
        $display("FAIL %s target_lvl actual %0d expected %0d", req, target_lvl, 2 + 16 * m_code);
      end
      n_chk++;
      if (smp_ready !== 1'b1) begin
        n_fail++;
        $display("FAIL R9 smp_ready actual %0b expected 1", smp_ready);
      end
    end
  end

  task automatic run(input int n, input logic [11:0] d);
    for (int i = 0; i < n; i++) begin
      smp_data = d;
      @(negedge clk);
    end
  endtask

  task automatic wr_ped(input logic [3:0] c);
    ped_wr = 1'b1; ped_code = c;
    @(negedge clk);
    ped_wr = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    #2 rst_n = 1'b0;
    #1 armed = 1'b1;
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: no valid, window open, high sample.
    req = "R9"; clamp_win = 1'b0; smp_valid = 1'b0;
    run(6, 12'd3000);

    // R3: open window, above then below target.
    req = "R3"; smp_valid = 1'b1;
    run(20, 12'd200);
    run(30, 12'd50);
    run(5, 12'd131);
    run(5, 12'd129);

    // R4: equal to target.
    req = "R4";
    run(8, 12'd130);

    // R2: pedestal writes at both ends, with samples at the new edges.
    req = "R2";
    smp_data = 12'd3000;
    wr_ped(4'd0);
    run(4, 12'd2);
    run(3, 12'd3);
    wr_ped(4'd15);
    run(4, 12'd242);
    run(3, 12'd243);
    run(3, 12'd241);
    wr_ped(4'd5);
    run(3, 12'd82);
    wr_ped(4'd8);

    // R6: polarity.
    req = "R6";
    win_pol = 1'b0; clamp_win = 1'b1;
    run(6, 12'd4000);
    win_pol = 1'b1; clamp_win = 1'b1;
    run(6, 12'd4000);
    clamp_win = 1'b0;
    run(6, 12'd0);
    win_pol = 1'b0;

    // R7: blanking freezes.
    req = "R7"; blank = 1'b1;
    run(8, 12'd4000);
    blank = 1'b0;

    // R8: standby masks the strobe under either polarity.
    req = "R8"; standby = 1'b1;
    run(6, 12'd0);
    win_pol = 1'b1; clamp_win = 1'b1;
    run(6, 12'd0);
    standby = 1'b0; win_pol = 1'b0; clamp_win = 1'b0;

    // R5: saturation at both rails.
    req = "R5";
    run(600, 12'd4095);
    run(1100, 12'd0);

    // R1: mid-run reset restores defaults.
    req = "R1";
    wr_ped(4'd3);
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Mixed randomized run.
    req = "R3";
    for (int i = 0; i < 3000; i++) begin
      smp_valid = ($urandom_range(0, 3) != 0);
      smp_data  = 12'($urandom_range(60, 200));
      clamp_win = $urandom_range(0, 1) == 1;
      win_pol   = $urandom_range(0, 1) == 1;
      blank     = ($urandom_range(0, 7) == 0);
      standby   = ($urandom_range(0, 15) == 0);
      ped_wr    = ($urandom_range(0, 31) == 0);
      ped_code  = 4'($urandom_range(0, 15));
      @(negedge clk);
    end
    ped_wr = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule